// File: doc/BRIEF.md
# Clock Power-Down Sequencer

This block sits between the clock synthesiser and the output drivers of a clock generator. It watches one external input that carries two meanings over the life of the device. After reset the input qualifies supply health. The sequencer keeps the oscillator and PLL off and every output parked until it sees the input high. From then on, the same input is an active-low power-down request. The block synchronises the request onto an always-running sampling clock. It parks every output at a clean boundary and only then removes the oscillator and PLL enables.

When the input is released, the block turns the oscillator and PLL back on together. It waits for the lock indication, then waits a parameterised number of cycles. After that, outputs rejoin their source clocks at a low phase, so no pulse is ever cut short. A strap input chooses what parked single-ended outputs present: a driven low, or a released driver with output-enable low. Differential pairs always park with both legs low. Source clocks are modelled as level signals sampled on the block clock, and lock is an input.

Top module: `pwrdn_seq`

## Requirements
- R1: While reset is high and on the first cycle after it: osc_en and pll_en are low, and all of se_out, diff_p and diff_n are low. Each se_oe bit equals the inverse of strap_hiz.
- R2: Before the pin has ever been seen high, a low pin does not act as a power-down request, and osc_en stays low. Once the pin is seen high, osc_en and pll_en rise within 6 cycles.
- R3: After pll_lock is first seen high in the enable phase, outputs stay low for at least EN_CYC cycles. Output activity resumes within EN_CYC+8 cycles.
- R4: A power-down is taken only when the synchronised pin is low on two consecutive clock edges. A low pulse lasting one clock period leaves osc_en high and outputs running.
- R5: A single-ended output never has a high pulse shorter than its source's high phase. Once parking has begun, no output shows a rising edge until outputs are released.
- R6: diff_p and diff_n are never high together. Both are low whenever osc_en is low.
- R7: osc_en and pll_en fall in the same cycle, and only when every output is already low.
- R8: While parked with clocks off, se_oe is all zeros if strap_hiz is 1 and all ones if it is 0. While outputs run, se_oe is all ones.
- R9: With clocks off, a high pin raises osc_en and pll_en together within 6 cycles.
- R10: While pll_lock stays low, outputs stay parked even after the pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_pin_n | input | 1 | Asynchronous dual-function pin: power-good, then active-low power-down |
| strap_hiz | input | 1 | 1: parked single-ended outputs released (oe low); 0: driven low |
| pll_lock | input | 1 | PLL lock indication |
| se_src | input | N_SE | Single-ended source clocks (levels) |
| diff_src | input | N_DIFF | Differential source clocks (levels) |
| se_out | output | N_SE | Gated single-ended outputs |
| se_oe | output | N_SE | Output enable per single-ended output |
| diff_p | output | N_DIFF | True leg of each differential output |
| diff_n | output | N_DIFF | Complement leg of each differential output |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |

## Verification
The bench drives low pulses of one, two, three and many cycles. A filter that reacts to a single low sample would shut clocks on a glitch. It also checks that the slowest single-ended output always keeps a full eight-cycle high phase. Parking on the request instead of on the falling edge would show up as a truncated pulse. It watches the cycle in which osc_en falls, because a sequencer that drops the oscillator before the slow lane parks leaves that output high at that moment. A directed case withholds lock after wake-up and then counts cycles from lock. Releasing outputs on the pin alone, or without the enable delay, would produce activity too early.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  typedef enum logic [2:0] {
    ST_PGOOD_WAIT = 3'd0,
    ST_RUN        = 3'd1,
    ST_PARK       = 3'd2,
    ST_OSC_OFF    = 3'd3,
    ST_PLL_START  = 3'd4,
    ST_ENABLE     = 3'd5
  } pd_state_e;
endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
  import pwrdn_pkg::*;
#(
  parameter int EN_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  input  logic all_parked,
  input  logic pll_lock,
  output logic park_req,
  output logic osc_en,
  output logic pll_en
);
  localparam int CW = $clog2(EN_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(EN_CYC - 1);

  pd_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic low_q;
  logic pd_det;
  logic run_d;

  // two consecutive low samples of the synchronised pin
  assign pd_det = ~pin_s & low_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PGOOD_WAIT: if (pin_s) state_d = ST_PLL_START;
      ST_PLL_START: begin
        if (pd_det)        state_d = ST_PARK;
        else if (pll_lock) state_d = ST_ENABLE;
      end
      ST_ENABLE: begin
        if (pd_det)                state_d = ST_PARK;
        else if (!pll_lock)        state_d = ST_PLL_START;
        else if (cnt_q == CNT_LAST) state_d = ST_RUN;
      end
      ST_RUN:     if (pd_det)     state_d = ST_PARK;
      ST_PARK:    if (all_parked) state_d = ST_OSC_OFF;
      ST_OSC_OFF: if (pin_s)      state_d = ST_PLL_START;
      default:                    state_d = ST_PGOOD_WAIT;
    endcase
  end

  assign run_d = (state_d == ST_PLL_START) || (state_d == ST_ENABLE) ||
                 (state_d == ST_RUN) || (state_d == ST_PARK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_PGOOD_WAIT;
      cnt_q   <= '0;
      low_q   <= 1'b0;
      osc_en  <= 1'b0;
      pll_en  <= 1'b0;
    end else begin
      state_q <= state_d;
      low_q   <= ~pin_s;
      cnt_q   <= (state_q == ST_ENABLE) ? cnt_q + 1'b1 : '0;
      osc_en  <= run_d;
      pll_en  <= run_d;
    end
  end

  assign park_req = (state_q != ST_RUN);
endmodule

// File: rtl/pd_se_gate.sv
module pd_se_gate #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  input  logic         park_req,
  input  logic         strap_hiz,
  output logic [W-1:0] out,
  output logic [W-1:0] oe,
  output logic [W-1:0] parked
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    logic park_q, out_q, oe_q, park_d;

    // park while low, or at the falling edge if high; release only in low phase
    always_comb begin
      if (park_req) park_d = park_q | ~out_q | ~src[i];
      else          park_d = park_q & src[i];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        park_q <= 1'b1;
        out_q  <= 1'b0;
        oe_q   <= ~strap_hiz;
      end else begin
        park_q <= park_d;
        out_q  <= park_d ? 1'b0 : src[i];
        oe_q   <= ~(park_d & strap_hiz);
      end
    end

    assign out[i]    = out_q;
    assign oe[i]     = oe_q;
    assign parked[i] = park_q;
  end
endmodule

// File: rtl/pd_diff_gate.sv
module pd_diff_gate #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  input  logic         park_req,
  output logic [W-1:0] out_p,
  output logic [W-1:0] out_n,
  output logic [W-1:0] parked
);
  for (genvar i = 0; i < W; i++) begin : g_pair
    logic park_q, p_q, n_q, park_d;

    // both legs park at once; release waits for a low source phase
    assign park_d = park_req | (park_q & src[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        park_q <= 1'b1;
        p_q    <= 1'b0;
        n_q    <= 1'b0;
      end else begin
        park_q <= park_d;
        p_q    <= park_d ? 1'b0 : src[i];
        n_q    <= park_d ? 1'b0 : ~src[i];
      end
    end

    assign out_p[i]  = p_q;
    assign out_n[i]  = n_q;
    assign parked[i] = park_q;
  end
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq #(
  parameter int N_SE      = 4,
  parameter int N_DIFF    = 2,
  parameter int EN_CYC    = 4,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pd_pin_n,
  input  logic              strap_hiz,
  input  logic              pll_lock,
  input  logic [N_SE-1:0]   se_src,
  input  logic [N_DIFF-1:0] diff_src,
  output logic [N_SE-1:0]   se_out,
  output logic [N_SE-1:0]   se_oe,
  output logic [N_DIFF-1:0] diff_p,
  output logic [N_DIFF-1:0] diff_n,
  output logic              osc_en,
  output logic              pll_en
);
  logic pin_s, park_req, all_parked;
  logic [N_SE-1:0]   se_parked;
  logic [N_DIFF-1:0] diff_parked;

  pd_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d_async(pd_pin_n), .d_sync(pin_s)
  );

  pd_fsm #(.EN_CYC(EN_CYC)) u_fsm (
    .clk(clk), .rst(rst), .pin_s(pin_s), .all_parked(all_parked),
    .pll_lock(pll_lock), .park_req(park_req), .osc_en(osc_en), .pll_en(pll_en)
  );

  pd_se_gate #(.W(N_SE)) u_se (
    .clk(clk), .rst(rst), .src(se_src), .park_req(park_req),
    .strap_hiz(strap_hiz), .out(se_out), .oe(se_oe), .parked(se_parked)
  );

  pd_diff_gate #(.W(N_DIFF)) u_diff (
    .clk(clk), .rst(rst), .src(diff_src), .park_req(park_req),
    .out_p(diff_p), .out_n(diff_n), .parked(diff_parked)
  );

  assign all_parked = (&se_parked) & (&diff_parked);
endmodule

// File: rtl/pwrdn_seq_chk.sv
module pwrdn_seq_chk #(
  parameter int N_SE   = 4,
  parameter int N_DIFF = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              strap_hiz,
  input logic [N_SE-1:0]   se_out,
  input logic [N_SE-1:0]   se_oe,
  input logic [N_DIFF-1:0] diff_p,
  input logic [N_DIFF-1:0] diff_n,
  input logic              osc_en,
  input logic              pll_en
);
  // R7
  osc_off_parked_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(osc_en) |-> (se_out == '0 && diff_p == '0 && diff_n == '0 && !pll_en));

  // R5
  parked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!osc_en && $past(!osc_en)) |-> ($stable(se_out) && $stable(diff_p) && $stable(diff_n)));

  // R8
  strap_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (!osc_en && $past(!osc_en)) |-> (se_oe == {N_SE{~$past(strap_hiz)}}));

  // R10
  release_needs_pll_chk: assert property (@(posedge clk) disable iff (rst)
    (se_out != '0 || diff_p != '0 || diff_n != '0) |-> (pll_en && osc_en));

  // R9
  wake_pair_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_en) |-> pll_en);

  // R6
  diff_legs_chk: assert property (@(posedge clk) disable iff (rst)
    (diff_p & diff_n) == '0);
endmodule

bind pwrdn_seq pwrdn_seq_chk #(.N_SE(N_SE), .N_DIFF(N_DIFF)) u_chk (
  .clk(clk), .rst(rst), .strap_hiz(strap_hiz), .se_out(se_out), .se_oe(se_oe),
  .diff_p(diff_p), .diff_n(diff_n), .osc_en(osc_en), .pll_en(pll_en)
);

// File: tb/tb_pwrdn_seq.sv
module tb_pwrdn_seq;
  localparam int N_SE = 4;
  localparam int N_DIFF = 2;
  localparam int EN_CYC = 4;
  localparam int SLOW_HI = 1 << (N_SE - 1);
  localparam int NVEC = 6;
  // each entry: {low cycles[7:0], strap, power-down expected}
  localparam logic [9:0] VEC [NVEC] = '{
    {8'd1, 1'b0, 1'b0}, {8'd2, 1'b0, 1'b1}, {8'd1, 1'b1, 1'b0},
    {8'd3, 1'b1, 1'b1}, {8'd12, 1'b0, 1'b1}, {8'd40, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, pd_pin_n = 1'b0, strap_hiz = 1'b1, pll_lock;
  logic [N_SE-1:0] se_out, se_oe;
  logic [N_DIFF-1:0] diff_p, diff_n;
  logic osc_en, pll_en;
  logic [7:0] ph = '0;
  logic allow_lock = 1'b1;
  int lk = 0;
  int errors = 0, checks = 0, cyc = 0;

  always @(negedge clk) ph <= ph + 1'b1;

  pwrdn_seq #(.N_SE(N_SE), .N_DIFF(N_DIFF), .EN_CYC(EN_CYC)) dut (
    .clk(clk), .rst(rst), .pd_pin_n(pd_pin_n), .strap_hiz(strap_hiz),
    .pll_lock(pll_lock), .se_src(ph[N_SE-1:0]), .diff_src(ph[N_DIFF-1:0]),
    .se_out(se_out), .se_oe(se_oe), .diff_p(diff_p), .diff_n(diff_n),
    .osc_en(osc_en), .pll_en(pll_en)
  );

  // PLL model: lock five cycles after enable
  always @(posedge clk) begin
    if (!pll_en) lk <= 0;
    else if (allow_lock && lk < 8) lk <= lk + 1;
  end
  assign pll_lock = (lk >= 5);

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic active();
    return (se_out != '0) || (diff_p != '0) || (diff_n != '0);
  endfunction

  // monitors: slow lane pulse width (R5) and outputs at oscillator shutdown (R7)
  int hi_run = 0;
  logic prev_hi = 1'b0, prev_osc = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      hi_run = 0; prev_hi = 1'b0; prev_osc = 1'b0;
    end else begin
      if (prev_hi && !se_out[N_SE-1]) chk("R5", "slow lane high width", hi_run, SLOW_HI);
      hi_run = se_out[N_SE-1] ? hi_run + 1 : 0;
      if (prev_osc && !osc_en) begin
        chk("R7", "outputs at osc off", {se_out, diff_p, diff_n}, 0);
        chk("R7", "pll_en with osc_en", pll_en, 0);
      end
      prev_hi = se_out[N_SE-1];
      prev_osc = osc_en;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_osc(input logic val, input int maxc, output bit ok);
    ok = 0;
    for (int k = 0; k < maxc; k++) begin
      @(negedge clk);
      if (osc_en == val) begin ok = 1; break; end
    end
  endtask

  task automatic wait_active(input int maxc, output bit ok);
    ok = 0;
    for (int k = 0; k < maxc; k++) begin
      @(negedge clk);
      if (active()) begin ok = 1; break; end
    end
  endtask

  initial begin
    bit ok;
    // R1 reset state, strap present
    repeat (3) @(negedge clk);
    chk("R1", "osc/pll in reset", {osc_en, pll_en}, 0);
    chk("R1", "outputs in reset", {se_out, diff_p, diff_n}, 0);
    chk("R1", "se_oe in reset", se_oe, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "outputs after reset", {osc_en, pll_en, se_out, diff_p, diff_n}, 0);
    // R2 low pin in power-good phase
    repeat (20) @(negedge clk);
    chk("R2", "osc_en while pin low before good", osc_en, 0);
    strap_hiz = 1'b0;
    pd_pin_n = 1'b1;
    wait_osc(1'b1, 6, ok);
    chk("R2", "osc_en after first high", ok, 1);
    chk("R2", "pll_en with osc_en", pll_en, 1);
    wait_active(40, ok);
    chk("R3", "outputs up after lock", ok, 1);
    repeat (20) @(negedge clk);

    // table walk: pulse lengths and strap settings
    for (int v = 0; v < NVEC; v++) begin
      int low_n;
      bit seen, rise_bad;
      logic [N_SE-1:0] prev_se;
      low_n = int'(VEC[v][9:2]);
      strap_hiz = VEC[v][1];
      repeat (3) @(negedge clk);
      pd_pin_n = 1'b0;
      seen = 0; rise_bad = 0; prev_se = se_out;
      for (int k = 1; k <= 60; k++) begin
        @(negedge clk);
        if (k >= 5 && ((se_out & ~prev_se) != '0)) rise_bad = 1;
        prev_se = se_out;
        if (!osc_en) begin
          seen = 1;
          chk("R8", "se_oe while parked", se_oe, VEC[v][1] ? 0 : {N_SE{1'b1}});
          chk("R6", "diff legs while parked", {diff_p, diff_n}, 0);
          break;
        end
        if (k == low_n) pd_pin_n = 1'b1;
      end
      chk("R4", $sformatf("power-down for %0d-cycle low", low_n), seen, VEC[v][0]);
      if (seen) begin
        chk("R5", "no rising edge after parking", rise_bad, 0);
        pd_pin_n = 1'b1;
        wait_osc(1'b1, 6, ok);
        chk("R9", "wake raises osc_en", ok, 1);
        chk("R9", "wake raises pll_en", pll_en, 1);
        wait_active(40, ok);
        chk("R3", "outputs back after wake", ok, 1);
      end else begin
        chk("R4", "osc_en kept on glitch", osc_en, 1);
        chk("R8", "se_oe while running", se_oe, {N_SE{1'b1}});
        wait_active(4, ok);
        chk("R4", "outputs running on glitch", ok, 1);
      end
      pd_pin_n = 1'b1;
      repeat (20) @(negedge clk);
    end

    // R10 lock withheld, then R3 cycle count from lock
    begin
      bit early;
      allow_lock = 1'b0;
      strap_hiz = 1'b0;
      pd_pin_n = 1'b0;
      wait_osc(1'b0, 60, ok);
      chk("R7", "shutdown reached", ok, 1);
      pd_pin_n = 1'b1;
      wait_osc(1'b1, 6, ok);
      chk("R9", "wake without lock", ok, 1);
      early = 0;
      repeat (30) begin @(negedge clk); if (active()) early = 1; end
      chk("R10", "outputs parked without lock", early, 0);
      allow_lock = 1'b1;
      while (!pll_lock) @(negedge clk);
      early = 0;
      for (int j = 0; j < EN_CYC; j++) begin
        @(negedge clk);
        if (active()) early = 1;
      end
      chk("R3", "no output within EN_CYC of lock", early, 0);
      wait_active(9, ok);
      chk("R3", "outputs within EN_CYC+8 of lock", ok, 1);
      repeat (20) @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule